// File: doc/BRIEF.md
# Pixel Limited-Range Clamp Unit

This block sits at the tail of a display pipeline. It forces every colour component of an RGB or YCbCr pixel into a legal video range before the pixel leaves for the output timing logic. Each pixel arrives as three components with a valid strobe, alongside a 3-bit clamp-mode select and three programmable floor/ceiling pairs, one pair per channel. The clamped pixel appears on a registered output one cycle after it enters.

Components narrower than the bus are carried MSB-aligned. The fixed limits for 8-, 10- and 12-bit video are therefore shifted up to the bus width, with zeros filling the bits below. The block captures the mode and the programmable limits only in cycles where no pixel is presented. A change made during a run of pixels therefore takes effect only after the next idle cycle, and no pixel is ever clamped with a mix of old and new settings.

Top module: `pclamp_top`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `out_valid` is 0 and `out_pix` is all zeros.
- R2: `out_valid` equals `in_valid` delayed by one clock. Pixels presented on consecutive cycles appear on consecutive cycles.
- R3: With clamp code 0, each output component equals the input component of the previous cycle.
- R4: With clamp code 1 (8-bit video, limits 0x01 and 0xFE shifted left by W-8), each component is limited to 0x010..0xFE0 when W=12.
- R5: With clamp code 2 (10-bit video, limits 0x004 and 0x3FB shifted left by W-10), each component is limited to 0x010..0xFEC when W=12.
- R6: With clamp code 3 (12-bit video, limits 0x010 and 0xFEF shifted left by W-12), each component is limited to 0x010..0xFEF when W=12.
- R7: With clamp code 4, channel k (bits [k*W +: W] of `in_pix`, `lim_min`, `lim_max` and `out_pix`; k=0 red, 1 green, 2 blue) is limited to its own `lim_min`..`lim_max` pair.
- R8: In code 4, if a channel's floor exceeds its ceiling, the output component is the ceiling.
- R9: Clamp codes 5, 6 and 7 behave as code 0.
- R10: The clamp code and the limits are captured only on clock edges where `in_valid` is 0. Changes to them while `in_valid` is high have no effect on any pixel until an idle cycle has passed.
- R11: On an edge where `in_valid` is 0, `out_pix` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A pixel is present on `in_pix` this cycle |
| in_mode | input | 3 | Clamp code (0 bypass, 1/2/3 preset video ranges, 4 programmable, 5-7 bypass) |
| in_pix | input | 3*W | Input components, channel k at bits [k*W +: W] |
| lim_min | input | 3*W | Programmable floors, channel k at bits [k*W +: W] |
| lim_max | input | 3*W | Programmable ceilings, channel k at bits [k*W +: W] |
| out_valid | output | 1 | Clamped pixel present on `out_pix` |
| out_pix | output | 3*W | Clamped components, same layout as `in_pix` |

## Verification
The bench builds the block with its default width of W=12. At that width the three preset ceilings land on distinct codes (0xFE0, 0xFEC, 0xFEF) while all three floors share 0x010, so a mixed-up ceiling table or a wrong alignment shift shows up directly as a wrong output code. The programmable vectors give each channel a different floor and ceiling and include an inverted pair. A swapped channel slice or the wrong order of the floor and ceiling comparisons is therefore visible at the ports. A directed burst changes the clamp code in the middle of a pixel run to show that the captured settings stay frozen.

// File: rtl/pclamp_pkg.sv
package pclamp_pkg;

  localparam int NUM_CH = 3;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    CLAMP_BYPASS = 3'd0,
    CLAMP_VID8   = 3'd1,
    CLAMP_VID10  = 3'd2,
    CLAMP_VID12  = 3'd3,
    CLAMP_PROG   = 3'd4
  } clamp_mode_e;

  // Floor of a preset video range for a given component depth, MSB-aligned
  // to a bus of width w. The floor is 2^(depth-8) at native depth.
  function automatic logic [31:0] preset_floor(int unsigned depth, int unsigned w);
    logic [31:0] native;
    native = 32'd1 << (depth - 8);
    return native << (w - depth);
  endfunction

  // Ceiling mirrors the floor from the top of the native code space.
  function automatic logic [31:0] preset_ceil(int unsigned depth, int unsigned w);
    logic [31:0] native;
    native = ((32'd1 << depth) - 32'd1) - (32'd1 << (depth - 8));
    return native << (w - depth);
  endfunction

endpackage

// File: rtl/pclamp_cfg_hold.sv
// Active configuration bank: reloaded only in idle cycles.
module pclamp_cfg_hold #(
  parameter int W   = 12,
  parameter int NCH = 3,
  localparam int VW = NCH * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [2:0]    mode_in,
  input  logic [VW-1:0] min_in,
  input  logic [VW-1:0] max_in,
  output logic [2:0]    mode_q,
  output logic [VW-1:0] min_q,
  output logic [VW-1:0] max_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= pclamp_pkg::CLAMP_BYPASS;
      min_q  <= '0;
      max_q  <= '1;
    end else if (load) begin
      mode_q <= mode_in;
      min_q  <= min_in;
      max_q  <= max_in;
    end
  end

endmodule

// File: rtl/pclamp_bounds.sv
// Selects the floor/ceiling pair for one channel from the active code.
module pclamp_bounds #(
  parameter int W = 12
) (
  input  logic [2:0]   mode,
  input  logic [W-1:0] prog_min,
  input  logic [W-1:0] prog_max,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi,
  output logic         pass
);

  localparam logic [W-1:0] LO8  = W'(pclamp_pkg::preset_floor(8,  W));
  localparam logic [W-1:0] HI8  = W'(pclamp_pkg::preset_ceil (8,  W));
  localparam logic [W-1:0] LO10 = W'(pclamp_pkg::preset_floor(10, W));
  localparam logic [W-1:0] HI10 = W'(pclamp_pkg::preset_ceil (10, W));
  localparam logic [W-1:0] LO12 = W'(pclamp_pkg::preset_floor(12, W));
  localparam logic [W-1:0] HI12 = W'(pclamp_pkg::preset_ceil (12, W));

  always_comb begin
    lo   = '0;
    hi   = '1;
    pass = 1'b0;
    case (mode)
      pclamp_pkg::CLAMP_VID8:  begin lo = LO8;      hi = HI8;      end
      pclamp_pkg::CLAMP_VID10: begin lo = LO10;     hi = HI10;     end
      pclamp_pkg::CLAMP_VID12: begin lo = LO12;     hi = HI12;     end
      pclamp_pkg::CLAMP_PROG:  begin lo = prog_min; hi = prog_max; end
      default:                 pass = 1'b1;
    endcase
  end

endmodule

// File: rtl/pclamp_lane.sv
// One component: raise to floor, then cap at ceiling, then register.
module pclamp_lane #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] x,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic         pass,
  output logic [W-1:0] y
);

  logic [W-1:0] raised;
  logic [W-1:0] capped;

  // Ceiling is applied last, so an inverted pair yields the ceiling.
  always_comb begin
    raised = (x < lo) ? lo : x;
    capped = (raised > hi) ? hi : raised;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y <= '0;
    end else if (en) begin
      y <= pass ? x : capped;
    end
  end

endmodule

// File: rtl/pclamp_top.sv
module pclamp_top #(
  parameter int W = 12,
  localparam int NCH = pclamp_pkg::NUM_CH,
  localparam int VW  = NCH * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [2:0]    in_mode,
  input  logic [VW-1:0] in_pix,
  input  logic [VW-1:0] lim_min,
  input  logic [VW-1:0] lim_max,
  output logic          out_valid,
  output logic [VW-1:0] out_pix
);

  logic [2:0]    act_mode;
  logic [VW-1:0] act_min;
  logic [VW-1:0] act_max;

  pclamp_cfg_hold #(.W(W), .NCH(NCH)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .load    (~in_valid),
    .mode_in (in_mode),
    .min_in  (lim_min),
    .max_in  (lim_max),
    .mode_q  (act_mode),
    .min_q   (act_min),
    .max_q   (act_max)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic [W-1:0] lo;
    logic [W-1:0] hi;
    logic         pass;

    pclamp_bounds #(.W(W)) u_bounds (
      .mode     (act_mode),
      .prog_min (act_min[k*W +: W]),
      .prog_max (act_max[k*W +: W]),
      .lo       (lo),
      .hi       (hi),
      .pass     (pass)
    );

    pclamp_lane #(.W(W)) u_lane (
      .clk  (clk),
      .rst  (rst),
      .en   (in_valid),
      .x    (in_pix[k*W +: W]),
      .lo   (lo),
      .hi   (hi),
      .pass (pass),
      .y    (out_pix[k*W +: W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

endmodule

// File: rtl/pclamp_checker.sv
module pclamp_checker #(
  parameter int W = 12,
  localparam int NCH = pclamp_pkg::NUM_CH,
  localparam int VW  = NCH * W
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [VW-1:0] in_pix,
  input logic          out_valid,
  input logic [VW-1:0] out_pix,
  input logic [2:0]    act_mode,
  input logic [VW-1:0] act_min,
  input logic [VW-1:0] act_max
);

  localparam logic [W-1:0] F8  = W'(pclamp_pkg::preset_floor(8,  W));
  localparam logic [W-1:0] C8  = W'(pclamp_pkg::preset_ceil (8,  W));
  localparam logic [W-1:0] F10 = W'(pclamp_pkg::preset_floor(10, W));
  localparam logic [W-1:0] C10 = W'(pclamp_pkg::preset_ceil (10, W));
  localparam logic [W-1:0] F12 = W'(pclamp_pkg::preset_floor(12, W));
  localparam logic [W-1:0] C12 = W'(pclamp_pkg::preset_ceil (12, W));

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_pix)); // R11
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> $stable({act_mode, act_min, act_max})); // R10
  AST_BYPASS_COPY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (act_mode == 3'd0 || act_mode >= 3'd5)) |=> out_pix == $past(in_pix)); // R3

  for (genvar k = 0; k < NCH; k++) begin : g_chk
    AST_VID8_RANGE: assert property (@(posedge clk) disable iff (rst)
      (in_valid && act_mode == 3'd1) |=>
        (out_pix[k*W +: W] >= F8 && out_pix[k*W +: W] <= C8)); // R4
    AST_VID10_RANGE: assert property (@(posedge clk) disable iff (rst)
      (in_valid && act_mode == 3'd2) |=>
        (out_pix[k*W +: W] >= F10 && out_pix[k*W +: W] <= C10)); // R5
    AST_VID12_RANGE: assert property (@(posedge clk) disable iff (rst)
      (in_valid && act_mode == 3'd3) |=>
        (out_pix[k*W +: W] >= F12 && out_pix[k*W +: W] <= C12)); // R6
    AST_PROG_CEIL: assert property (@(posedge clk) disable iff (rst)
      (in_valid && act_mode == 3'd4) |=>
        out_pix[k*W +: W] <= $past(act_max[k*W +: W])); // R8
  end

endmodule

bind pclamp_top pclamp_checker #(.W(W)) u_pclamp_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_pix    (in_pix),
  .out_valid (out_valid),
  .out_pix   (out_pix),
  .act_mode  (act_mode),
  .act_min   (act_min),
  .act_max   (act_max)
);

// File: tb/test_pclamp_top.sv
`timescale 1ns/1ps
module test_pclamp_top;

  localparam int W  = 12;
  localparam int VW = 3 * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [2:0]    in_mode = 3'd0;
  logic [VW-1:0] in_pix = '0;
  logic [VW-1:0] lim_min = '0;
  logic [VW-1:0] lim_max = '0;
  logic          out_valid;
  logic [VW-1:0] out_pix;

  int nchk  = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  pclamp_top #(.W(W)) i_pclamp_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
    .in_pix(in_pix), .lim_min(lim_min), .lim_max(lim_max),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  typedef struct packed {
    logic [2:0]    mode;
    logic [VW-1:0] pix;
    logic [VW-1:0] mn;
    logic [VW-1:0] mx;
    logic [VW-1:0] exp;
    logic [7:0]    rq;
  } vec_t;

  localparam int NV = 12;
  // Component order in each 36-bit word: {blue, green, red}
  localparam vec_t VECS [NV] = '{
    '{3'd0, 36'hFFF_000_123, 36'h0, 36'h0, 36'hFFF_000_123, 8'd3},             // R3
    '{3'd1, 36'hFFF_000_800, 36'h0, 36'h0, 36'hFE0_010_800, 8'd4},             // R4
    '{3'd1, 36'hFE1_00F_FE0, 36'h0, 36'h0, 36'hFE0_010_FE0, 8'd4},             // R4
    '{3'd2, 36'hFFF_000_FED, 36'h0, 36'h0, 36'hFEC_010_FEC, 8'd5},             // R5
    '{3'd2, 36'hFEC_010_011, 36'h0, 36'h0, 36'hFEC_010_011, 8'd5},             // R5
    '{3'd3, 36'hFFF_00F_FF0, 36'h0, 36'h0, 36'hFEF_010_FEF, 8'd6},             // R6
    '{3'd3, 36'hFEE_010_7FF, 36'h0, 36'h0, 36'hFEE_010_7FF, 8'd6},             // R6
    '{3'd4, 36'h000_FFF_500, 36'h300_200_100, 36'hC00_B00_A00, 36'h300_B00_500, 8'd7}, // R7
    '{3'd4, 36'h0FF_FFF_050, 36'h100_020_060, 36'hEFF_FFE_070, 36'h100_FFE_060, 8'd7}, // R7
    '{3'd4, 36'h123_456_000, 36'h000_000_800, 36'hFFF_FFF_400, 36'h123_456_400, 8'd8}, // R8
    '{3'd5, 36'hFFF_000_ABC, 36'h0, 36'h0, 36'hFFF_000_ABC, 8'd9},             // R9
    '{3'd7, 36'h001_FFE_FFF, 36'h0, 36'h0, 36'h001_FFE_FFF, 8'd9}              // R9
  };

  task automatic check(string rq, logic [VW-1:0] act, logic [VW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", {35'd0, out_valid}, '0);
    check("R1 out_pix in reset", out_pix, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 out_valid after reset", {35'd0, out_valid}, '0);
    check("R1 out_pix after reset", out_pix, '0);

    // Table walk: idle cycle loads settings, one pixel, check next cycle
    for (int i = 0; i < NV; i++) begin
      in_valid = 1'b0;
      in_mode  = VECS[i].mode;
      lim_min  = VECS[i].mn;
      lim_max  = VECS[i].mx;
      @(negedge clk);
      in_valid = 1'b1;
      in_pix   = VECS[i].pix;
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R2 valid vec %0d", i), {35'd0, out_valid}, 36'd1);
      check($sformatf("R%0d data vec %0d", VECS[i].rq, i), out_pix, VECS[i].exp);
    end

    // R11: idle cycles with wiggling inputs leave the output untouched
    in_pix = 36'h555_AAA_333;
    @(negedge clk);
    check("R11 hold while idle", out_pix, VECS[NV-1].exp);
    check("R2 valid low when idle", {35'd0, out_valid}, '0);

    // R10: clamp code change inside a burst is not applied
    in_mode = 3'd1;
    @(negedge clk);
    in_valid = 1'b1;
    in_pix   = 36'hFFF_FFF_FFF;
    @(negedge clk);
    check("R10 first pixel of burst", out_pix, 36'hFE0_FE0_FE0);
    in_mode = 3'd0;
    lim_max = '0;
    @(negedge clk);
    check("R10 code change mid-burst ignored", out_pix, 36'hFE0_FE0_FE0);
    check("R2 back-to-back valid", {35'd0, out_valid}, 36'd1);
    in_pix = 36'h000_000_000;
    @(negedge clk);
    check("R10 floor still from captured code", out_pix, 36'h010_010_010);
    in_valid = 1'b0;
    @(negedge clk);
    check("R11 hold after burst", out_pix, 36'h010_010_010);
    in_valid = 1'b1;
    in_pix   = 36'hFFF_FFF_FFF;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 new code after idle cycle", out_pix, 36'hFFF_FFF_FFF);

    // R1: reset mid-stream clears the outputs
    in_valid = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check("R1 out_pix on reset", out_pix, '0);
    check("R1 out_valid on reset", {35'd0, out_valid}, '0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    summary();
  end

endmodule